// File: doc/BRIEF.md
# Auto-Stepping Memory Address Register

This block holds the pointer that selects a memory word for pointer-addressed accesses. It keeps two copies of the pointer, a foreground copy and a background copy, and only the copy belonging to the active register set can be loaded, observed, or stepped. The other copy keeps its value untouched until its set is made active again.

The pointer is loaded either by a direct load instruction or by an instruction that carries an absolute address. The decoder folds both into one load strobe with its value, and that value then addresses the next pointer-based access. After an instruction that addresses memory through the pointer, the pointer steps by one word. It also steps after a data access that reaches the end-limit segment while the persistent source or destination is pointer-addressed memory. A 2-bit mode field chooses the step direction: up, down, or none. The memory, the segment counters and the instruction decoder are outside the block. The end-of-segment event and the persistent-target qualifier arrive as inputs.

Top module: `step_ptr`

## Requirements
- R1: While reset is asserted and right after it, both pointer copies are zero and the foreground set is active (`bg_active` = 0, `ptr` = 0).
- R2: With `ld_en` high at a clock edge, the active copy takes `ld_val`, and `ptr` shows that value after the edge.
- R3: With mode `2'b01` and a step event, the active copy increases by one modulo 2^AW, so the maximum value wraps to zero.
- R4: With mode `2'b10` and a step event, the active copy decreases by one modulo 2^AW, so zero wraps to the maximum value.
- R5: With mode `2'b00` or `2'b11`, a step event leaves the pointer unchanged.
- R6: A step event is `ptr_use` high, or `seg_end` and `persist_ptr` both high. `seg_end` without `persist_ptr` causes no step. Several step events in one cycle step the pointer once.
- R7: When `ld_en` and a step event occur in the same cycle, the pointer takes `ld_val` and does not step.
- R8: Only the active copy is loaded or stepped, and the inactive copy keeps its value. Any load or step in a cycle goes to the copy that was active at the start of that cycle.
- R9: `sel_we` high at a clock edge makes the background set active if `sel_bg` = 1, or the foreground set if `sel_bg` = 0. `bg_active` and `ptr` follow the selection after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_we | input | 1 | Write strobe for the register-set select |
| sel_bg | input | 1 | Set to make active: 1 background, 0 foreground |
| mode | input | 2 | Step mode: 01 up, 10 down, 00/11 none |
| ld_en | input | 1 | Load the active copy (direct or absolute-address instruction) |
| ld_val | input | AW | Value to load |
| ptr_use | input | 1 | Instruction that addressed memory through the pointer |
| seg_end | input | 1 | Data access reached the end-limit segment |
| persist_ptr | input | 1 | Persistent source/destination is pointer-addressed memory |
| ptr | output | AW | Value of the active pointer copy |
| bg_active | output | 1 | 1 when the background set is active |

## Verification
The hardest case to reach is the background copy keeping its value while the foreground copy steps and wraps. The two copies can only be seen one at a time, so this can only be shown by switching sets. The stimulus loads distinct values into both copies, steps one copy across the wrap boundary, and then switches back to read the other. In some of those cycles it also switches sets while a load or step is in flight, to confirm that the operation lands in the copy that was active before the switch. A long run of random load, step, mode and select traffic is then compared against the bench model every cycle.

// File: rtl/step_ptr.sv
module step_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic          sel_bg,
  input  logic [1:0]    mode,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          ptr_use,
  input  logic          seg_end,
  input  logic          persist_ptr,
  output logic [AW-1:0] ptr,
  output logic          bg_active
);
  localparam logic [1:0]    M_UP = 2'b01;
  localparam logic [1:0]    M_DN = 2'b10;
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic          bank_q;
  logic [AW-1:0] fg_q, bg_q, cur, nxt;
  wire           step = ptr_use | (seg_end & persist_ptr);

  assign cur       = bank_q ? bg_q : fg_q;
  assign ptr       = cur;
  assign bg_active = bank_q;

  always_comb begin
    nxt = cur;
    if (ld_en)
      nxt = ld_val;
    else if (step) begin
      if (mode == M_UP)      nxt = cur + ONE;
      else if (mode == M_DN) nxt = cur - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       fg_q <= '0;
    else if (!bank_q) fg_q <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bg_q <= '0;
    else if (bank_q) bg_q <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bank_q <= 1'b0;
    else if (sel_we) bank_q <= sel_bg;

  always_comb
    if (!rst_n) assert_reset_clear_R1: assert (ptr == '0 && !bg_active);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !sel_we) |=> ptr == $past(ld_val));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !sel_we && ptr_use && mode == M_UP) |=> ptr == $past(ptr) + ONE);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !sel_we && ptr_use && mode == M_DN) |=> ptr == $past(ptr) - ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !sel_we && (mode == 2'b00 || mode == 2'b11)) |=> $stable(ptr));

  assert_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !sel_we && !ptr_use && !(seg_end && persist_ptr)) |=> $stable(ptr));

  assert_fg_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q |=> $stable(fg_q));

  assert_bg_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_q |=> $stable(bg_q));

  assert_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> bg_active == $past(sel_bg));
endmodule

// File: tb/test_step_ptr.sv
module test_step_ptr;
  localparam int AW  = 10;
  localparam int DEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_we = 0, sel_bg = 0, ld_en = 0, ptr_use = 0, seg_end = 0, persist_ptr = 0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] ld_val = '0;
  logic [AW-1:0] ptr;
  logic          bg_active;

  int n_cmp = 0, n_bad = 0;
  int m_fg = 0, m_bg = 0, m_act = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  step_ptr #(.AW(AW)) i_step_ptr (
    .clk, .rst_n, .sel_we, .sel_bg, .mode, .ld_en, .ld_val,
    .ptr_use, .seg_end, .persist_ptr, .ptr, .bg_active
  );

  task automatic compare();
    int exp_p;
    exp_p = m_act ? m_bg : m_fg;
    n_cmp++;
    if (int'(ptr) != exp_p || int'(bg_active) != m_act) begin
      n_bad++;
      $display("FAIL %s: ptr=%0d bg_active=%0d expected ptr=%0d bg_active=%0d",
               tag, ptr, bg_active, exp_p, m_act);
    end
  endtask

  // apply inputs at a falling edge and advance the model to the next rising edge
  task automatic apply(input string t, input bit we, input bit bg, input logic [1:0] md,
                       input bit ld, input int lv, input bit pu, input bit se, input bit pp);
    int cur, nx;
    sel_we = we; sel_bg = bg; mode = md; ld_en = ld; ld_val = lv[AW-1:0];
    ptr_use = pu; seg_end = se; persist_ptr = pp;
    cur = m_act ? m_bg : m_fg;
    nx = cur;
    if (ld) nx = lv % DEP;
    else if (pu || (se && pp)) begin
      if (md == 2'b01) nx = (cur + 1) % DEP;
      else if (md == 2'b10) nx = (cur + DEP - 1) % DEP;
    end
    if (m_act != 0) m_bg = nx; else m_fg = nx;
    if (we) m_act = bg ? 1 : 0;
    @(negedge clk);
    tag = t;
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare();
    apply("R2", 0, 0, 2'b00, 1, 'h155, 0, 0, 0);
    apply("R3", 0, 0, 2'b01, 0, 0, 1, 0, 0);
    apply("R2", 0, 0, 2'b01, 1, DEP - 1, 0, 0, 0);
    apply("R3", 0, 0, 2'b01, 0, 0, 1, 0, 0);
    apply("R4", 0, 0, 2'b10, 0, 0, 1, 0, 0);
    apply("R4", 0, 0, 2'b10, 0, 0, 0, 1, 1);
    apply("R5", 0, 0, 2'b11, 0, 0, 1, 1, 1);
    apply("R5", 0, 0, 2'b00, 0, 0, 1, 0, 0);
    apply("R6", 0, 0, 2'b01, 0, 0, 0, 1, 0);
    apply("R6", 0, 0, 2'b01, 0, 0, 0, 0, 1);
    apply("R6", 0, 0, 2'b01, 0, 0, 1, 1, 1);
    apply("R7", 0, 0, 2'b01, 1, 'h0AA, 1, 1, 1);
    apply("R9", 1, 1, 2'b00, 0, 0, 0, 0, 0);
    apply("R8", 0, 0, 2'b00, 1, 'h321, 0, 0, 0);
    apply("R8", 0, 0, 2'b10, 1, 0, 0, 0, 0);
    apply("R8", 0, 0, 2'b10, 0, 0, 1, 0, 0);
    apply("R8", 1, 0, 2'b01, 0, 0, 1, 0, 0);
    apply("R8", 0, 0, 2'b01, 0, 0, 1, 0, 0);
    apply("R8", 1, 1, 2'b01, 1, 'h010, 0, 0, 0);
    apply("R9", 1, 0, 2'b00, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      apply("R8", (r % 11) == 0, r[4], r[6:5], (r % 13) == 0, $urandom % DEP,
            r[8] & r[9], r[10], r[11]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule